// File: doc/BRIEF.md
# Speculative Operation State Buffer

This block records every wide instruction issued by a core that runs several speculative traces as hardware threads. Each issued instruction takes one circular-buffer entry that holds its PC, the label of the trace it belongs to, the set of operation slots that carry real work, and two bits per slot: one for "finished" and one for "stalled". The issue logic gets the entry index back. Every operation then carries that index and its slot number, so that execution units can report completion or a stall on that exact bit.

The oldest entry leaves the buffer once all of its used slots have finished and none has stalled. A stall on any operation makes the block ask the trace controller, one cycle later, to run a different trace. The block also remembers which trace stalled, so that execution can come back to it once the miss is serviced. A mispredicted trace is removed by invalidating every entry that carries its label. A committed trace is kept and entries of every other label are removed. A per-label bitmap shows which traces still have instructions in flight.

Top module: `spec_op_state_buf`

## Requirements
- R1: After reset no entry is valid, both pointers are at entry 0, `issue_ready_o` is 1, `issue_addr_o` is 0, and `retire_o`, `switch_req_o`, `exc_label_o` and `live_labels_o` are all 0.
- R2: An accepted issue writes PC, label and slot mask into the entry shown on `issue_addr_o`. That index then moves up by one, wrapping modulo the depth.
- R3: The buffer is full when the number of positions from head to tail equals the depth. Positions already invalidated still count until the head passes them. While full, `issue_ready_o` is 0, an issue request is ignored, and `issue_addr_o` does not move.
- R4: A completion report (entry index, slot number) sets that slot's finished bit and clears its stalled bit. The report is acted on only when the entry is valid and the slot is set in the entry's mask.
- R5: If the head entry is valid, every slot in its mask has finished, and no stalled bit is set, then `retire_o` is 1 and `retire_pc_o` holds its PC during that cycle. At the next edge the entry is cleared and the head moves on. Slots outside the mask never hold back retirement. At most one entry retires per cycle.
- R6: A stall report on a valid entry and a masked slot sets that slot's stalled bit. In the next cycle `switch_req_o` is 1 and `exc_label_o` shows the stalled entry's label. `exc_label_o` keeps that value until the next stall report.
- R7: A mispredict event invalidates every valid entry whose label matches, except an entry being issued in the same cycle. `switch_req_o` is 1 in the next cycle. If the head entry is invalidated, it does not raise `retire_o`.
- R8: A commit event invalidates every valid entry whose label differs from the committed label.
- R9: Bit L of `live_labels_o` is 1 exactly when at least one valid entry carries label L.
- R10: When a completion report and a stall report name the same slot of the same entry in one cycle, the stall wins: the stalled bit ends up set and the finished bit is set as well.
- R11: When the head sits on an invalidated position and the buffer is not empty, the head moves on by one position per cycle and `retire_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Request to allocate an entry |
| issue_pc_i | input | 32 | PC of the issued instruction |
| issue_label_i | input | 2 | Trace label of the issued instruction |
| issue_mask_i | input | 4 | Slots that carry an operation |
| issue_ready_o | output | 1 | An entry is free |
| issue_addr_o | output | 4 | Index of the entry the next issue takes |
| done_valid_i | input | 1 | Completion report strobe |
| done_addr_i | input | 4 | Entry index of the completed operation |
| done_slot_i | input | 2 | Slot number of the completed operation |
| stall_valid_i | input | 1 | Stall report strobe |
| stall_addr_i | input | 4 | Entry index of the stalled operation |
| stall_slot_i | input | 2 | Slot number of the stalled operation |
| mispredict_valid_i | input | 1 | A trace was mispredicted |
| mispredict_label_i | input | 2 | Label of the mispredicted trace |
| commit_valid_i | input | 1 | A trace was confirmed |
| commit_label_i | input | 2 | Label of the confirmed trace |
| retire_o | output | 1 | The head entry retires this cycle |
| retire_pc_o | output | 32 | PC of the head entry |
| switch_req_o | output | 1 | Request to switch to another trace |
| exc_label_o | output | 2 | Label of the most recently stalled trace |
| live_labels_o | output | 4 | One bit per label with instructions in flight |

## Verification
The main function is driven with three kinds of patterns. The first is a directed completion order with sparse slot masks, which shows whether unused slots block the head. The second runs a stall and a later completion on the same slot, and also sends both reports in one cycle; this separates the clearing of a stall from its priority. The third fills the buffer to capacity, which shows refusal and the wrap of the index. A long stretch of random issue, completion, stall, mispredict and commit traffic with a fixed seed then mixes holes, flushes and retirements in orders the directed cases do not reach. Every cycle of that stretch is compared against a reference model kept in the bench.

// File: rtl/sosb_pkg.sv
package sosb_pkg;
  // action applied to one buffer entry at the next edge
  typedef enum logic [1:0] {
    ENT_HOLD = 2'd0,
    ENT_LOAD = 2'd1,
    ENT_DROP = 2'd2
  } ent_act_e;
endpackage

// File: rtl/sosb_ptr_ctrl.sv
module sosb_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_req_i,
  input  logic          adv_i,
  output logic [AW-1:0] head_o,
  output logic [AW-1:0] tail_o,
  output logic          full_o,
  output logic          nonempty_o,
  output logic          push_o
);
  // one extra wrap bit tells full from empty
  logic [AW:0] head_q, tail_q;

  assign head_o     = head_q[AW-1:0];
  assign tail_o     = tail_q[AW-1:0];
  assign full_o     = (head_q[AW] != tail_q[AW]) && (head_q[AW-1:0] == tail_q[AW-1:0]);
  assign nonempty_o = (head_q != tail_q);
  assign push_o     = push_req_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push_o) tail_q <= tail_q + 1'b1;
      if (adv_i)  head_q <= head_q + 1'b1;
    end
  end
endmodule

// File: rtl/sosb_entry.sv
module sosb_entry
  import sosb_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int PC_W    = 32,
  parameter int LABEL_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ent_act_e           act_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [LABEL_W-1:0] label_i,
  input  logic [NSLOT-1:0]   mask_i,
  input  logic [NSLOT-1:0]   set_exec_i,
  input  logic [NSLOT-1:0]   set_exc_i,
  output logic               valid_o,
  output logic [PC_W-1:0]    pc_o,
  output logic [LABEL_W-1:0] label_o,
  output logic [NSLOT-1:0]   mask_o,
  output logic               complete_o
);
  logic               valid_q;
  logic [PC_W-1:0]    pc_q;
  logic [LABEL_W-1:0] label_q;
  logic [NSLOT-1:0]   mask_q, exec_q, exc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
      label_q <= '0;
      mask_q  <= '0;
      exec_q  <= '0;
      exc_q   <= '0;
    end else begin
      unique case (act_i)
        ENT_LOAD: begin
          valid_q <= 1'b1;
          pc_q    <= pc_i;
          label_q <= label_i;
          mask_q  <= mask_i;
          exec_q  <= '0;
          exc_q   <= '0;
        end
        ENT_DROP: begin
          valid_q <= 1'b0;
          exec_q  <= '0;
          exc_q   <= '0;
        end
        default: begin
          exec_q <= exec_q | set_exec_i;
          // a stall report outranks a same-cycle completion
          exc_q  <= (exc_q & ~set_exec_i) | set_exc_i;
        end
      endcase
    end
  end

  assign valid_o    = valid_q;
  assign pc_o       = pc_q;
  assign label_o    = label_q;
  assign mask_o     = mask_q;
  assign complete_o = valid_q && ((exec_q & mask_q) == mask_q) && (exc_q == '0);
endmodule

// File: rtl/sosb_label_track.sv
module sosb_label_track #(
  parameter int DEPTH   = 16,
  parameter int LABEL_W = 2,
  localparam int NLABEL = 1 << LABEL_W
) (
  input  logic [DEPTH-1:0]   valid_i,
  input  logic [LABEL_W-1:0] label_i [DEPTH],
  output logic [NLABEL-1:0]  live_o
);
  for (genvar l = 0; l < NLABEL; l++) begin : g_lbl
    logic [DEPTH-1:0] hit;
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      assign hit[e] = valid_i[e] && (label_i[e] == LABEL_W'(l));
    end
    assign live_o[l] = |hit;
  end
endmodule

// File: rtl/spec_op_state_buf.sv
module spec_op_state_buf
  import sosb_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NSLOT   = 4,
  parameter int PC_W    = 32,
  parameter int LABEL_W = 2,
  localparam int AW     = $clog2(DEPTH),
  localparam int SW     = $clog2(NSLOT),
  localparam int NLABEL = 1 << LABEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_valid_i,
  input  logic [PC_W-1:0]    issue_pc_i,
  input  logic [LABEL_W-1:0] issue_label_i,
  input  logic [NSLOT-1:0]   issue_mask_i,
  output logic               issue_ready_o,
  output logic [AW-1:0]      issue_addr_o,
  input  logic               done_valid_i,
  input  logic [AW-1:0]      done_addr_i,
  input  logic [SW-1:0]      done_slot_i,
  input  logic               stall_valid_i,
  input  logic [AW-1:0]      stall_addr_i,
  input  logic [SW-1:0]      stall_slot_i,
  input  logic               mispredict_valid_i,
  input  logic [LABEL_W-1:0] mispredict_label_i,
  input  logic               commit_valid_i,
  input  logic [LABEL_W-1:0] commit_label_i,
  output logic               retire_o,
  output logic [PC_W-1:0]    retire_pc_o,
  output logic               switch_req_o,
  output logic [LABEL_W-1:0] exc_label_o,
  output logic [NLABEL-1:0]  live_labels_o
);
  logic [AW-1:0]      head_idx, tail_idx;
  logic               full, nonempty, push, adv_head;
  logic [DEPTH-1:0]   ent_valid, ent_complete, ent_kill;
  logic [PC_W-1:0]    ent_pc    [DEPTH];
  logic [LABEL_W-1:0] ent_label [DEPTH];
  logic [NSLOT-1:0]   ent_mask  [DEPTH];
  logic               done_hit, stall_hit;
  logic [NSLOT-1:0]   done_oh, stall_oh;
  logic               switch_q;
  logic [LABEL_W-1:0] trace_ptr_q;

  sosb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_req_i (issue_valid_i),
    .adv_i      (adv_head),
    .head_o     (head_idx),
    .tail_o     (tail_idx),
    .full_o     (full),
    .nonempty_o (nonempty),
    .push_o     (push)
  );

  // report decode: only valid entries and masked slots count
  assign done_hit  = done_valid_i && ent_valid[done_addr_i] && ent_mask[done_addr_i][done_slot_i];
  assign stall_hit = stall_valid_i && ent_valid[stall_addr_i] && ent_mask[stall_addr_i][stall_slot_i];
  assign done_oh   = {{(NSLOT-1){1'b0}}, 1'b1} << done_slot_i;
  assign stall_oh  = {{(NSLOT-1){1'b0}}, 1'b1} << stall_slot_i;

  // flush wins over retirement of the head
  assign retire_o    = ent_complete[head_idx] && !ent_kill[head_idx];
  assign retire_pc_o = ent_pc[head_idx];
  assign adv_head    = retire_o || (nonempty && !ent_valid[head_idx]);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    ent_act_e         act;
    logic [NSLOT-1:0] set_exec, set_exc;

    assign ent_kill[e] = ent_valid[e] &&
        ((mispredict_valid_i && (ent_label[e] == mispredict_label_i)) ||
         (commit_valid_i && (ent_label[e] != commit_label_i)));

    always_comb begin
      if (push && (tail_idx == AW'(e)))                        act = ENT_LOAD;
      else if (ent_kill[e] || (retire_o && head_idx == AW'(e))) act = ENT_DROP;
      else                                                       act = ENT_HOLD;
    end

    assign set_exec = (done_hit  && done_addr_i  == AW'(e)) ? done_oh  : '0;
    assign set_exc  = (stall_hit && stall_addr_i == AW'(e)) ? stall_oh : '0;

    sosb_entry #(
      .NSLOT   (NSLOT),
      .PC_W    (PC_W),
      .LABEL_W (LABEL_W)
    ) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (act),
      .pc_i       (issue_pc_i),
      .label_i    (issue_label_i),
      .mask_i     (issue_mask_i),
      .set_exec_i (set_exec),
      .set_exc_i  (set_exc),
      .valid_o    (ent_valid[e]),
      .pc_o       (ent_pc[e]),
      .label_o    (ent_label[e]),
      .mask_o     (ent_mask[e]),
      .complete_o (ent_complete[e])
    );
  end

  sosb_label_track #(
    .DEPTH   (DEPTH),
    .LABEL_W (LABEL_W)
  ) u_live (
    .valid_i (ent_valid),
    .label_i (ent_label),
    .live_o  (live_labels_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      switch_q    <= 1'b0;
      trace_ptr_q <= '0;
    end else begin
      switch_q <= stall_hit || mispredict_valid_i;
      if (stall_hit) trace_ptr_q <= ent_label[stall_addr_i];
    end
  end

  assign issue_ready_o = !full;
  assign issue_addr_o  = tail_idx;
  assign switch_req_o  = switch_q;
  assign exc_label_o   = trace_ptr_q;
endmodule

// File: rtl/sosb_checker.sv
module sosb_checker #(
  parameter int AW      = 4,
  parameter int LABEL_W = 2,
  parameter int NLABEL  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               issue_valid_i,
  input logic               issue_ready_o,
  input logic [AW-1:0]      issue_addr_o,
  input logic               mispredict_valid_i,
  input logic               retire_o,
  input logic               switch_req_o,
  input logic [LABEL_W-1:0] exc_label_o,
  input logic [NLABEL-1:0]  live_labels_o
);
  a_r2_tail_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && issue_ready_o |=> issue_addr_o == $past(issue_addr_o) + 1'b1);

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_ready_o |=> issue_addr_o == $past(issue_addr_o));

  a_r6_label_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !switch_req_o |-> $stable(exc_label_o));

  a_r7_switch_on_mispredict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_valid_i |=> switch_req_o);

  a_r9_retire_is_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |-> (live_labels_o != '0));
endmodule

bind spec_op_state_buf sosb_checker #(
  .AW      (AW),
  .LABEL_W (LABEL_W),
  .NLABEL  (NLABEL)
) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .issue_valid_i      (issue_valid_i),
  .issue_ready_o      (issue_ready_o),
  .issue_addr_o       (issue_addr_o),
  .mispredict_valid_i (mispredict_valid_i),
  .retire_o           (retire_o),
  .switch_req_o       (switch_req_o),
  .exc_label_o        (exc_label_o),
  .live_labels_o      (live_labels_o)
);

// File: tb/spec_op_state_buf_bench.sv
module spec_op_state_buf_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_valid_i;
  logic [31:0] issue_pc_i;
  logic [1:0]  issue_label_i;
  logic [3:0]  issue_mask_i;
  logic        issue_ready_o;
  logic [3:0]  issue_addr_o;
  logic        done_valid_i;
  logic [3:0]  done_addr_i;
  logic [1:0]  done_slot_i;
  logic        stall_valid_i;
  logic [3:0]  stall_addr_i;
  logic [1:0]  stall_slot_i;
  logic        mispredict_valid_i;
  logic [1:0]  mispredict_label_i;
  logic        commit_valid_i;
  logic [1:0]  commit_label_i;
  logic        retire_o;
  logic [31:0] retire_pc_o;
  logic        switch_req_o;
  logic [1:0]  exc_label_o;
  logic [3:0]  live_labels_o;

  always #4 clk_i = ~clk_i;

  spec_op_state_buf u_spec_op_state_buf (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  bit        m_valid [16];
  bit [31:0] m_pc    [16];
  bit [1:0]  m_label [16];
  bit [3:0]  m_mask  [16];
  bit [3:0]  m_exec  [16];
  bit [3:0]  m_exc   [16];
  int        m_head, m_tail;
  bit        m_switch;
  bit [1:0]  m_tptr;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_cnt();
    return (m_tail - m_head + 32) % 32;
  endfunction

  function automatic bit [3:0] exp_live();
    bit [3:0] l = '0;
    for (int e = 0; e < 16; e++) if (m_valid[e]) l[m_label[e]] = 1'b1;
    return l;
  endfunction

  function automatic bit exp_kill(int e);
    return m_valid[e] && ((mispredict_valid_i && m_label[e] == mispredict_label_i) ||
                          (commit_valid_i && m_label[e] != commit_label_i));
  endfunction

  function automatic bit exp_retire();
    int h = m_head % 16;
    bit comp = m_valid[h] && ((m_exec[h] & m_mask[h]) == m_mask[h]) && (m_exc[h] == 4'd0);
    return comp && !exp_kill(h);
  endfunction

  task automatic idle();
    issue_valid_i = 0; issue_pc_i = '0; issue_label_i = '0; issue_mask_i = '0;
    done_valid_i = 0; done_addr_i = '0; done_slot_i = '0;
    stall_valid_i = 0; stall_addr_i = '0; stall_slot_i = '0;
    mispredict_valid_i = 0; mispredict_label_i = '0;
    commit_valid_i = 0; commit_label_i = '0;
  endtask

  task automatic model_reset();
    for (int e = 0; e < 16; e++) begin
      m_valid[e] = 0; m_pc[e] = '0; m_label[e] = '0;
      m_mask[e] = '0; m_exec[e] = '0; m_exc[e] = '0;
    end
    m_head = 0; m_tail = 0; m_switch = 0; m_tptr = '0;
  endtask

  // compare the outputs of the current cycle with the model
  task automatic settle();
    bit r;
    #1;
    r = exp_retire();
    chk("R3 ready", issue_ready_o, m_cnt() != 16);
    chk("R2 addr", issue_addr_o, m_tail % 16);
    chk("R5 retire", retire_o, r);
    if (r) chk("R5 retire_pc", retire_pc_o, m_pc[m_head % 16]);
    chk("R6/R7 switch", switch_req_o, m_switch);
    chk("R6 exc_label", exc_label_o, m_tptr);
    chk("R9 live", live_labels_o, exp_live());
  endtask

  task automatic model_step();
    int  h = m_head % 16;
    int  t = m_tail % 16;
    bit  push = issue_valid_i && (m_cnt() != 16);
    bit  ret = exp_retire();
    bit  adv = ret || (m_cnt() != 0 && !m_valid[h]);
    bit  dh = done_valid_i && m_valid[done_addr_i] && m_mask[done_addr_i][done_slot_i];
    bit  sh = stall_valid_i && m_valid[stall_addr_i] && m_mask[stall_addr_i][stall_slot_i];
    bit  kill [16];
    bit [1:0] slab = m_label[stall_addr_i];
    for (int e = 0; e < 16; e++) kill[e] = exp_kill(e);
    for (int e = 0; e < 16; e++) begin
      if (push && e == t) begin
        m_valid[e] = 1; m_pc[e] = issue_pc_i; m_label[e] = issue_label_i;
        m_mask[e] = issue_mask_i; m_exec[e] = '0; m_exc[e] = '0;
      end else if (kill[e] || (ret && e == h)) begin
        m_valid[e] = 0; m_exec[e] = '0; m_exc[e] = '0;
      end else begin
        if (dh && done_addr_i == e) begin
          m_exec[e][done_slot_i] = 1'b1;
          m_exc[e][done_slot_i]  = 1'b0;
        end
        if (sh && stall_addr_i == e) m_exc[e][stall_slot_i] = 1'b1;
      end
    end
    m_switch = sh || mispredict_valid_i;
    if (sh) m_tptr = slab;
    if (push) m_tail = (m_tail + 1) % 32;
    if (adv)  m_head = (m_head + 1) % 32;
  endtask

  task automatic advance();
    model_step();
    @(negedge clk_i);
    idle();
  endtask

  task automatic cyc();
    settle();
    advance();
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 0;
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic put(bit [31:0] pc, bit [1:0] lab, bit [3:0] mask);
    issue_valid_i = 1; issue_pc_i = pc; issue_label_i = lab; issue_mask_i = mask;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    settle();
    chk("R1 ready", issue_ready_o, 1);
    chk("R1 addr", issue_addr_o, 0);
    chk("R1 retire", retire_o, 0);
    chk("R1 switch", switch_req_o, 0);
    chk("R1 label", exc_label_o, 0);
    chk("R1 live", live_labels_o, 0);
    advance();

    // R5 sparse mask: slots 0 and 2 only
    put(32'h100, 2'd0, 4'b0101); settle(); chk("R2 first addr", issue_addr_o, 0); advance();
    done_valid_i = 1; done_addr_i = 0; done_slot_i = 0; cyc();
    settle(); chk("R5 partial", retire_o, 0);
    done_valid_i = 1; done_addr_i = 0; done_slot_i = 2; advance();
    settle(); chk("R5 done", retire_o, 1); chk("R5 pc", retire_pc_o, 32'h100); advance();
    settle(); chk("R5 single", retire_o, 0); advance();

    // R6 stall then R4 late completion clears it
    put(32'h200, 2'd1, 4'b0011); cyc();
    stall_valid_i = 1; stall_addr_i = 1; stall_slot_i = 0; cyc();
    settle(); chk("R6 switch", switch_req_o, 1); chk("R6 label", exc_label_o, 1);
    done_valid_i = 1; done_addr_i = 1; done_slot_i = 1; advance();
    settle(); chk("R6 pulse", switch_req_o, 0); chk("R6 held", exc_label_o, 1);
    done_valid_i = 1; done_addr_i = 1; done_slot_i = 0; advance();
    settle(); chk("R4 clear stall", retire_o, 1); advance();

    // R10 stall and completion on the same slot
    put(32'h300, 2'd2, 4'b0001); cyc();
    done_valid_i = 1; done_addr_i = 2; done_slot_i = 0;
    stall_valid_i = 1; stall_addr_i = 2; stall_slot_i = 0; cyc();
    settle(); chk("R10 stall wins", retire_o, 0); chk("R10 switch", switch_req_o, 1);
    chk("R10 label", exc_label_o, 2); advance();

    // R7 mispredict removes the stuck entry, R11 hole skipped
    mispredict_valid_i = 1; mispredict_label_i = 2; settle();
    chk("R7 no retire", retire_o, 0); advance();
    settle(); chk("R7 switch", switch_req_o, 1); chk("R7 live", live_labels_o, 0);
    chk("R11 no strobe", retire_o, 0); advance();

    // R8 commit keeps one label
    put(32'h400, 2'd0, 4'b1111); cyc();
    put(32'h500, 2'd1, 4'b1111); cyc();
    put(32'h600, 2'd3, 4'b1111); cyc();
    settle(); chk("R9 three live", live_labels_o, 4'b1011); advance();
    commit_valid_i = 1; commit_label_i = 1; cyc();
    settle(); chk("R8 commit", live_labels_o, 4'b0010); advance();

    // R3 fill to capacity after a fresh reset
    do_reset();
    for (int i = 0; i < 16; i++) begin
      put(32'h1000 + i, 2'(i), 4'b1111); cyc();
    end
    put(32'hdead, 2'd0, 4'b1111); settle();
    chk("R3 full", issue_ready_o, 0); chk("R3 addr wrap", issue_addr_o, 0); advance();
    settle(); chk("R3 ignored", issue_addr_o, 0); advance();
    for (int s = 0; s < 4; s++) begin
      done_valid_i = 1; done_addr_i = 0; done_slot_i = 2'(s); cyc();
    end
    settle(); chk("R5 after full", retire_pc_o, 32'h1000); chk("R3 retire", retire_o, 1); advance();
    settle(); chk("R3 freed", issue_ready_o, 1); advance();

    // random traffic against the model
    do_reset();
    void'($urandom(32'd5150));
    for (int n = 0; n < 6000; n++) begin
      if ($urandom % 100 < 40) put($urandom, 2'($urandom), 4'($urandom));
      if ($urandom % 100 < 70) begin
        done_valid_i = 1;
        done_addr_i  = 4'((m_head + $urandom % 5) % 16);
        done_slot_i  = 2'($urandom);
      end
      if ($urandom % 100 < 4) begin
        stall_valid_i = 1;
        stall_addr_i  = 4'((m_head + $urandom % 5) % 16);
        stall_slot_i  = 2'($urandom);
      end
      if ($urandom % 100 < 2) begin
        mispredict_valid_i = 1; mispredict_label_i = 2'($urandom);
      end
      if ($urandom % 100 < 2) begin
        commit_valid_i = 1; commit_label_i = 2'($urandom);
      end
      cyc();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule